// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Flag

This block is the purely combinational integer stage of a load-store RISC pipeline. Each evaluation takes two register values, a 16-bit constant field, a 5-bit shift count and an operation code. It returns a 32-bit result together with an overflow flag. The operations are:

- addition and subtraction, each in a trapping and a wrapping form;
- the four bitwise operations;
- signed and unsigned less-than compare;
- shifts by a constant or by a register amount;
- placing a constant in the upper half of the word.

The block only raises the overflow flag. The surrounding core decides what to do with it, normally by dropping the register write and taking an exception. The result port always carries the wrapped arithmetic value. Constant operands are widened inside the block. Arithmetic and compare operations sign-extend the constant, and bitwise operations zero-extend it. The caller therefore only has to pick the operation code.

Top module: `intexec_alu`

## Requirements
- R1: `op_i` selects the operation with these codes. Codes 0..5 are add-trap, add-wrap, sub-trap, sub-wrap, add-constant-trap and add-constant-wrap. Codes 6..9 are AND, OR, XOR and NOR. Codes 10..12 are AND-, OR- and XOR-with-constant. Codes 13..16 are signed less-than, unsigned less-than, signed less-than-constant and unsigned less-than-constant. Code 17 is upper-constant. Codes 18..20 are left-logical, right-logical and right-arithmetic by `shamt_i`. Codes 21..23 are the same three shifts by `a_i`. Register operations use `a_i` as the first operand and `b_i` as the second. Constant forms use `a_i` and the widened `imm_i`. Shifts move `b_i`.
- R2: `ovf_o` can be 1 only for codes 0, 2 and 4. Every other code drives it 0.
- R3: An add overflows when both operands share a sign and the 32-bit sum has the other sign. A subtract overflows when the operand signs differ and the difference's sign differs from `a_i`. In every case `result_o` holds the sum or difference modulo 2^32.
- R4: The constant is sign-extended for codes 4, 5, 15 and 16, and zero-extended for codes 10, 11 and 12.
- R5: Less-than operations write 1 or 0 into the full 32-bit result. Codes 13 and 15 compare in two's complement, and codes 14 and 16 compare as unsigned numbers. For example, 0xFFFFFFFF < 1 is true for signed and false for unsigned.
- R6: NOR returns the complement of (`a_i` OR `b_i`). AND, OR and XOR return the bitwise function of the two operands.
- R7: Upper-constant places `imm_i` in bits 31:16 and zeros bits 15:0.
- R8: Register-amount shifts use only `a_i[4:0]` as the amount. The upper bits of `a_i` have no effect on the result.
- R9: Right-arithmetic shifts fill the vacated bits with `b_i[31]`. Logical shifts fill them with 0.
- R10: Codes 24..31 give `result_o` = 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First register operand; also the source of register shift amounts |
| b_i | input | 32 | Second register operand; also the value being shifted |
| imm_i | input | 16 | Constant field from the instruction |
| shamt_i | input | 5 | Constant shift count |
| op_i | input | 5 | Operation code (see R1) |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow on a trapping add or subtract |

## Verification
Every operation code, including the unused ones, is crossed with a table of register values. The table holds:

- zero and one;
- both sign-boundary words, 0x7FFFFFFF and 0x80000000;
- all-ones;
- values whose upper bits are set while their low five bits hold a small count.

The register pairs are in turn crossed with constants on both sides of the 16-bit sign bit. Pairs at the sign boundaries separate overflow from wrap-around, and separate signed from unsigned ordering. Constants 0x8000 and 0xFFFF distinguish sign extension from zero extension. Register shift counts above 31 show that only the low five bits are used. Negative shifted values show whether the right shift fills with the sign bit or with zeros.

// File: rtl/intexec_pkg.sv
package intexec_pkg;

   typedef enum logic [4:0] {
      OP_ADD_TRAP  = 5'd0,
      OP_ADD_WRAP  = 5'd1,
      OP_SUB_TRAP  = 5'd2,
      OP_SUB_WRAP  = 5'd3,
      OP_ADDK_TRAP = 5'd4,
      OP_ADDK_WRAP = 5'd5,
      OP_AND       = 5'd6,
      OP_OR        = 5'd7,
      OP_XOR       = 5'd8,
      OP_NOR       = 5'd9,
      OP_ANDK      = 5'd10,
      OP_ORK       = 5'd11,
      OP_XORK      = 5'd12,
      OP_LT_S      = 5'd13,
      OP_LT_U      = 5'd14,
      OP_LTK_S     = 5'd15,
      OP_LTK_U     = 5'd16,
      OP_HIGHK     = 5'd17,
      OP_SHL_K     = 5'd18,
      OP_SHR_K     = 5'd19,
      OP_SHRA_K    = 5'd20,
      OP_SHL_R     = 5'd21,
      OP_SHR_R     = 5'd22,
      OP_SHRA_R    = 5'd23
   } op_e;

   typedef enum logic [2:0] {
      U_NONE,
      U_ARITH,
      U_LOGIC,
      U_CMP,
      U_SHIFT,
      U_HIGH
   } unit_e;

   typedef enum logic [1:0] {
      L_AND,
      L_OR,
      L_XOR,
      L_NOR
   } lfn_e;

   typedef struct packed {
      unit_e unit;
      logic  use_k;    // second operand is the widened constant
      logic  k_sext;   // constant widened with its sign bit
      logic  sub;      // subtract instead of add
      logic  trap;     // overflow may be reported
      logic  cmp_u;    // unsigned ordering
      lfn_e  lfn;
      logic  sh_left;
      logic  sh_arith;
      logic  sh_reg;   // amount from first operand
   } ctl_t;

   function automatic ctl_t decode(input logic [4:0] code);
      ctl_t c;
      c = '{unit: U_NONE, use_k: 1'b0, k_sext: 1'b0, sub: 1'b0, trap: 1'b0,
            cmp_u: 1'b0, lfn: L_AND, sh_left: 1'b0, sh_arith: 1'b0, sh_reg: 1'b0};
      case (code)
         OP_ADD_TRAP:  begin c.unit = U_ARITH; c.trap = 1'b1; end
         OP_ADD_WRAP:  c.unit = U_ARITH;
         OP_SUB_TRAP:  begin c.unit = U_ARITH; c.sub = 1'b1; c.trap = 1'b1; end
         OP_SUB_WRAP:  begin c.unit = U_ARITH; c.sub = 1'b1; end
         OP_ADDK_TRAP: begin c.unit = U_ARITH; c.use_k = 1'b1; c.k_sext = 1'b1; c.trap = 1'b1; end
         OP_ADDK_WRAP: begin c.unit = U_ARITH; c.use_k = 1'b1; c.k_sext = 1'b1; end
         OP_AND:       begin c.unit = U_LOGIC; c.lfn = L_AND; end
         OP_OR:        begin c.unit = U_LOGIC; c.lfn = L_OR;  end
         OP_XOR:       begin c.unit = U_LOGIC; c.lfn = L_XOR; end
         OP_NOR:       begin c.unit = U_LOGIC; c.lfn = L_NOR; end
         OP_ANDK:      begin c.unit = U_LOGIC; c.lfn = L_AND; c.use_k = 1'b1; end
         OP_ORK:       begin c.unit = U_LOGIC; c.lfn = L_OR;  c.use_k = 1'b1; end
         OP_XORK:      begin c.unit = U_LOGIC; c.lfn = L_XOR; c.use_k = 1'b1; end
         OP_LT_S:      begin c.unit = U_CMP; c.sub = 1'b1; end
         OP_LT_U:      begin c.unit = U_CMP; c.sub = 1'b1; c.cmp_u = 1'b1; end
         OP_LTK_S:     begin c.unit = U_CMP; c.sub = 1'b1; c.use_k = 1'b1; c.k_sext = 1'b1; end
         OP_LTK_U:     begin c.unit = U_CMP; c.sub = 1'b1; c.use_k = 1'b1; c.k_sext = 1'b1;
                             c.cmp_u = 1'b1; end
         OP_HIGHK:     c.unit = U_HIGH;
         OP_SHL_K:     begin c.unit = U_SHIFT; c.sh_left = 1'b1; end
         OP_SHR_K:     c.unit = U_SHIFT;
         OP_SHRA_K:    begin c.unit = U_SHIFT; c.sh_arith = 1'b1; end
         OP_SHL_R:     begin c.unit = U_SHIFT; c.sh_left = 1'b1; c.sh_reg = 1'b1; end
         OP_SHR_R:     begin c.unit = U_SHIFT; c.sh_reg = 1'b1; end
         OP_SHRA_R:    begin c.unit = U_SHIFT; c.sh_arith = 1'b1; c.sh_reg = 1'b1; end
         default:      c.unit = U_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/intexec_opsel.sv
module intexec_opsel
   import intexec_pkg::*;
#(
   parameter int W     = 32,
   parameter int K_W   = 16,
   parameter int SH_W  = 5
) (
   input  logic [4:0]      op_i,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   input  logic [K_W-1:0]  imm_i,
   input  logic [SH_W-1:0] shamt_i,
   output ctl_t            ctl_o,
   output logic [W-1:0]    opb_o,
   output logic [SH_W-1:0] amt_o
);
   localparam int EXT_W = W - K_W;

   logic [W-1:0] k_wide;

   assign ctl_o  = decode(op_i);
   assign k_wide = {{EXT_W{ctl_o.k_sext & imm_i[K_W-1]}}, imm_i};
   assign opb_o  = ctl_o.use_k ? k_wide : b_i;
   // Only the low count bits of a register amount are used
   assign amt_o  = ctl_o.sh_reg ? a_i[SH_W-1:0] : shamt_i;

endmodule

// File: rtl/intexec_addsub.sv
module intexec_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         ovf_o,
   output logic         lt_s_o,
   output logic         lt_u_o
);
   localparam int MSB = W - 1;

   logic [W-1:0] y_eff;
   logic [W:0]   full;
   logic         sx, sy_eff, sr;

   assign y_eff = sub_i ? ~y_i : y_i;
   assign full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, sub_i};
   assign sum_o = full[W-1:0];

   assign sx     = x_i[MSB];
   assign sy_eff = y_eff[MSB];
   assign sr     = full[MSB];

   // same effective operand signs and a flipped result sign
   assign ovf_o  = (sx == sy_eff) && (sr != sx);

   // ordering derived from the difference (valid when sub_i is set)
   assign lt_s_o = (x_i[MSB] != y_i[MSB]) ? x_i[MSB] : sr;
   assign lt_u_o = ~full[W];

endmodule

// File: rtl/intexec_shift.sv
module intexec_shift #(
   parameter int W      = 32,
   parameter int SH_W   = 5,
   parameter int STAGED = 1
) (
   input  logic [W-1:0]    din_i,
   input  logic [SH_W-1:0] amt_i,
   input  logic            left_i,
   input  logic            arith_i,
   output logic [W-1:0]    dout_o
);
   localparam int MSB = W - 1;

   logic fill;
   assign fill = arith_i & din_i[MSB];

   generate
      if (STAGED != 0) begin : g_staged
         logic [W-1:0] l_st [SH_W+1];
         logic [W-1:0] r_st [SH_W+1];
         assign l_st[0] = din_i;
         assign r_st[0] = din_i;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int D = 1 << k;
            assign l_st[k+1] = amt_i[k] ? {l_st[k][W-1-D:0], {D{1'b0}}} : l_st[k];
            assign r_st[k+1] = amt_i[k] ? {{D{fill}}, r_st[k][W-1:D]} : r_st[k];
         end
         assign dout_o = left_i ? l_st[SH_W] : r_st[SH_W];
      end else begin : g_flat
         logic [2*W-1:0] ext;
         logic [2*W-1:0] rsh;
         assign ext    = {{W{fill}}, din_i};
         assign rsh    = ext >> amt_i;
         assign dout_o = left_i ? (din_i << amt_i) : rsh[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/intexec_alu.sv
module intexec_alu
   import intexec_pkg::*;
#(
   parameter int W          = 32,
   parameter int K_W        = 16,
   parameter int SHIFT_STGD = 1
) (
   input  logic [W-1:0]         a_i,
   input  logic [W-1:0]         b_i,
   input  logic [K_W-1:0]       imm_i,
   input  logic [$clog2(W)-1:0] shamt_i,
   input  logic [4:0]           op_i,
   output logic [W-1:0]         result_o,
   output logic                 ovf_o
);
   localparam int SH_W  = $clog2(W);
   localparam int LOW_W = W - K_W;

   generate
      if (W != (1 << SH_W)) begin : g_bad_width
         $error("intexec_alu: W must be a power of two");
      end
      if (K_W * 2 != W) begin : g_bad_k
         $error("intexec_alu: constant field must be half the word");
      end
   endgenerate

   ctl_t              ctl;
   logic [W-1:0]      opb;
   logic [SH_W-1:0]   amt;
   logic [W-1:0]      sum;
   logic              ovf_raw, lt_s, lt_u;
   logic [W-1:0]      sh_out;
   logic [W-1:0]      log_out;

   intexec_opsel #(.W(W), .K_W(K_W), .SH_W(SH_W)) u_opsel (
      .op_i    (op_i),
      .a_i     (a_i),
      .b_i     (b_i),
      .imm_i   (imm_i),
      .shamt_i (shamt_i),
      .ctl_o   (ctl),
      .opb_o   (opb),
      .amt_o   (amt)
   );

   intexec_addsub #(.W(W)) u_addsub (
      .x_i    (a_i),
      .y_i    (opb),
      .sub_i  (ctl.sub),
      .sum_o  (sum),
      .ovf_o  (ovf_raw),
      .lt_s_o (lt_s),
      .lt_u_o (lt_u)
   );

   intexec_shift #(.W(W), .SH_W(SH_W), .STAGED(SHIFT_STGD)) u_shift (
      .din_i   (b_i),
      .amt_i   (amt),
      .left_i  (ctl.sh_left),
      .arith_i (ctl.sh_arith),
      .dout_o  (sh_out)
   );

   always_comb begin
      case (ctl.lfn)
         L_AND:   log_out = a_i & opb;
         L_OR:    log_out = a_i | opb;
         L_XOR:   log_out = a_i ^ opb;
         default: log_out = ~(a_i | opb);
      endcase
   end

   always_comb begin
      case (ctl.unit)
         U_ARITH: result_o = sum;
         U_LOGIC: result_o = log_out;
         U_CMP:   result_o = {{(W-1){1'b0}}, (ctl.cmp_u ? lt_u : lt_s)};
         U_SHIFT: result_o = sh_out;
         U_HIGH:  result_o = {imm_i, {LOW_W{1'b0}}};
         default: result_o = '0;
      endcase
   end

   assign ovf_o = (ctl.unit == U_ARITH) && ctl.trap && ovf_raw;

endmodule

// File: rtl/intexec_alu_chk.sv
module intexec_alu_chk #(
   parameter int W   = 32,
   parameter int K_W = 16
) (
   input logic [W-1:0]   a_i,
   input logic [W-1:0]   b_i,
   input logic [K_W-1:0] imm_i,
   input logic [4:0]     op_i,
   input logic [W-1:0]   result_o,
   input logic           ovf_o
);
   logic known;
   assign known = !$isunknown({a_i, b_i, imm_i, op_i, result_o, ovf_o});

   always_comb begin
      if (known) begin
         AST_OVF_TRAP_ONLY: assert (!ovf_o || op_i == 5'd0 || op_i == 5'd2 || op_i == 5'd4); // R2
         AST_ADD_WRAPS: assert (op_i != 5'd0 || result_o == a_i + b_i); // R3
         AST_LOGIC_K_ZEXT: assert (!(op_i inside {5'd10, 5'd12}) || result_o[W-1:K_W] == a_i[W-1:K_W]
                                   || op_i == 5'd10); // R4
         AST_ANDK_HIGH_ZERO: assert (op_i != 5'd10 || result_o[W-1:K_W] == '0); // R4
         AST_LT_BOOLEAN: assert (!(op_i inside {5'd13, 5'd14, 5'd15, 5'd16}) || result_o[W-1:1] == '0); // R5
         AST_NOR_FUNC: assert (op_i != 5'd9 || result_o == ~(a_i | b_i)); // R6
         AST_HIGHK_PLACE: assert (op_i != 5'd17 || result_o == {imm_i, {(W-K_W){1'b0}}}); // R7
         AST_UNUSED_QUIET: assert (op_i < 5'd24 || (result_o == '0 && !ovf_o)); // R10
      end
   end

endmodule

bind intexec_alu intexec_alu_chk #(.W(W), .K_W(K_W)) u_chk (
   .a_i      (a_i),
   .b_i      (b_i),
   .imm_i    (imm_i),
   .op_i     (op_i),
   .result_o (result_o),
   .ovf_o    (ovf_o)
);

// File: tb/intexec_alu_test.sv
module intexec_alu_test;
   import intexec_pkg::*;

   logic        clk = 1'b0;
   logic [31:0] a, b;
   logic [15:0] imm;
   logic [4:0]  shamt;
   logic [4:0]  op;
   logic [31:0] result;
   logic        ovf;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   intexec_alu uut (
      .a_i      (a),
      .b_i      (b),
      .imm_i    (imm),
      .shamt_i  (shamt),
      .op_i     (op),
      .result_o (result),
      .ovf_o    (ovf)
   );

   localparam int NV = 10;
   localparam int NK = 6;
   logic [31:0] vtab [NV] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_8000,
                              32'h0000_7FFF, 32'hF0F0_0021};
   logic [15:0] ktab [NK] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
   logic [4:0]  stab [4]  = '{5'd0, 5'd1, 5'd15, 5'd31};

   function automatic string tag_of(input logic [4:0] o);
      if (o inside {5'd0, 5'd2, 5'd4})            return "R3";
      if (o inside {5'd1, 5'd3, 5'd5})            return "R2";
      if (o inside {5'd6, 5'd7, 5'd8, 5'd9})      return "R6";
      if (o inside {5'd10, 5'd11, 5'd12})         return "R4";
      if (o inside {5'd13, 5'd14, 5'd15, 5'd16})  return "R5";
      if (o == 5'd17)                             return "R7";
      if (o inside {5'd21, 5'd22, 5'd23})         return "R8";
      if (o inside {5'd18, 5'd19, 5'd20})         return "R9";
      return "R10";
   endfunction

   // returns {overflow, result}
   function automatic logic [32:0] model(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                                         input logic [15:0] k, input logic [4:0] s);
      logic [31:0] ks, kz, r;
      longint      wide;
      logic        v;
      ks = {{16{k[15]}}, k};
      kz = {16'h0000, k};
      r = 32'h0;
      v = 1'b0;
      case (o)
         5'd0, 5'd1: begin
            r = x + y;
            wide = longint'($signed(x)) + longint'($signed(y));
            v = (o == 5'd0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
         end
         5'd2, 5'd3: begin
            r = x - y;
            wide = longint'($signed(x)) - longint'($signed(y));
            v = (o == 5'd2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
         end
         5'd4, 5'd5: begin
            r = x + ks;
            wide = longint'($signed(x)) + longint'($signed(ks));
            v = (o == 5'd4) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
         end
         5'd6:  r = x & y;
         5'd7:  r = x | y;
         5'd8:  r = x ^ y;
         5'd9:  r = ~(x | y);
         5'd10: r = x & kz;
         5'd11: r = x | kz;
         5'd12: r = x ^ kz;
         5'd13: r = {31'h0, $signed(x) < $signed(y)};
         5'd14: r = {31'h0, x < y};
         5'd15: r = {31'h0, $signed(x) < $signed(ks)};
         5'd16: r = {31'h0, x < ks};
         5'd17: r = {k, 16'h0000};
         5'd18: r = y << s;
         5'd19: r = y >> s;
         5'd20: r = $unsigned($signed(y) >>> s);
         5'd21: r = y << x[4:0];
         5'd22: r = y >> x[4:0];
         5'd23: r = $unsigned($signed(y) >>> x[4:0]);
         default: r = 32'h0;
      endcase
      return {v, r};
   endfunction

   task automatic apply(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic [15:0] k, input logic [4:0] s, input string tag);
      logic [32:0] exp;
      @(posedge clk);
      op = o; a = x; b = y; imm = k; shamt = s;
      @(negedge clk);
      exp = model(o, x, y, k, s);
      n_vec++;
      if (result !== exp[31:0] || ovf !== exp[32]) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: got res=%h ovf=%b, expected res=%h ovf=%b",
                  tag, o, x, y, k, s, result, ovf, exp[31:0], exp[32]);
      end
   endtask

   initial begin
      op = 5'd0; a = '0; b = '0; imm = '0; shamt = '0;
      // all-zero inputs: zero result, no overflow (R3)
      apply(5'd0, 32'h0, 32'h0, 16'h0, 5'd0, "R3");
      // directed corners
      apply(5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, "R3");          // overflow, wrapped sum
      apply(5'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, "R2");          // wrapping: no flag
      apply(5'd2, 32'h8000_0000, 32'h1, 16'h0, 5'd0, "R3");          // subtract overflow
      apply(5'd4, 32'h8000_0000, 32'hDEAD_BEEF, 16'h8000, 5'd0, "R4");
      apply(5'd13, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, "R5");         // signed: 1
      apply(5'd14, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, "R5");         // unsigned: 0
      apply(5'd16, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0, "R4");      // vs 0xFFFFFFFF
      apply(5'd11, 32'h0, 32'h0, 16'h8000, 5'd0, "R4");              // zero-extend
      apply(5'd21, 32'hFFFF_FFE4, 32'h1, 16'h0, 5'd0, "R8");         // amount 4
      apply(5'd23, 32'h0000_0021, 32'h8000_0000, 16'h0, 5'd0, "R9");
      apply(5'd20, 32'h0, 32'h8000_0000, 16'h0, 5'd31, "R9");
      apply(5'd19, 32'h0, 32'h8000_0000, 16'h0, 5'd31, "R9");
      apply(5'd17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hA5C3, 5'd7, "R7");
      apply(5'd27, 32'h7FFF_FFFF, 32'h1, 16'hFFFF, 5'd3, "R10");
      // sweep: every code over every operand pair and constant (R1)
      for (int o = 0; o < 32; o++) begin
         for (int ia = 0; ia < NV; ia++) begin
            for (int ib = 0; ib < NV; ib++) begin
               for (int ik = 0; ik < NK; ik++) begin
                  apply(5'(o), vtab[ia], vtab[ib], ktab[ik], stab[(ia + ib + ik) % 4],
                        tag_of(5'(o)));
               end
            end
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog expired: got unfinished run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule